// File: doc/BRIEF.md
# Real-Time Clock Prescaler and Update Sequencer

This block sits between a 32.768 kHz reference and the time-keeping logic of a real-time clock. It counts qualified reference ticks in a binary prescaler, emits a one-clock update strobe once per second, and raises an update-in-progress status bit a fixed number of reference ticks before each strobe. Software that sees that bit low knows it has at least that long to read the time fields safely. The same prescaler also supplies a selectable periodic tick and a square wave derived from it.

A 3-bit chain-control field selects one of three states. The chain can run, it can be frozen, or it can be held at the half-second point so that the first update after release arrives half a second later. A software hold input stops updates from being issued while the time fields are being written. The prescaler keeps counting during that hold, so the phase of the second is preserved.

Top module: `rtc_divider_ctl`

## Requirements
- R1: While `rst_n` is low, `upd_strobe`, `uip`, `per_tick` and `sqw_out` are all 0.
- R2: With `dv_sel` = 3'b110 or 3'b111 (hold), the prescaler is forced to its half-second value, 2^(DIV_W-1). While this holds, `uip`, `upd_strobe`, `per_tick` and `sqw_out` are 0 from the next clock on.
- R3: With any `dv_sel` other than 3'b010 or 3'b11x (stop), the prescaler is frozen. No `upd_strobe` or `per_tick` occurs and `sqw_out` keeps its value.
- R4: With `dv_sel` = 3'b010 (run), the first `upd_strobe` after release from hold follows 2^(DIV_W-1) qualified ticks. Later strobes follow every 2^DIV_W qualified ticks. A stop or a gap in `ref_en` delays them by its length.
- R5: `upd_strobe` is a single-clock pulse, issued one clock after the qualified tick that wraps the prescaler.
- R6: `uip` rises UIP_LEAD qualified ticks before each `upd_strobe` and falls in the same clock that `upd_strobe` goes high. Every strobe is preceded by that full window.
- R7: While `set_hold` is 1, no `upd_strobe` is issued and `uip` is 0. Raising `set_hold` during the window clears `uip` and skips that update. The prescaler and periodic tick keep running.
- R8: `rate_sel` = 0 disables the periodic tick, and `sqw_out` is then 0.
- R9: `rate_sel` = n (1..2^RATE_W-1) gives one `per_tick` every 2^(n-1) qualified ticks. The period is clamped to 2^DIV_W when n-1 exceeds DIV_W, and those ticks coincide with the update wrap.
- R10: With `sqw_en` = 1, `sqw_out` toggles in the clock of each `per_tick`. With `sqw_en` = 0, `sqw_out` is 0.
- R11: A clock with `ref_en` = 0 advances nothing and produces no `upd_strobe` or `per_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-clock enable per 32.768 kHz reference tick |
| dv_sel | input | 3 | Chain control: 010 run, 11x hold at half second, others stop |
| rate_sel | input | RATE_W | Periodic tap select, 0 = off |
| sqw_en | input | 1 | Square-wave output enable |
| set_hold | input | 1 | Software hold: suppresses updates and the status bit |
| upd_strobe | output | 1 | One-clock pulse per second |
| uip | output | 1 | Update-in-progress status |
| per_tick | output | 1 | Periodic tap pulse |
| sqw_out | output | 1 | Square wave toggling on each periodic pulse |

## Verification
On every cycle the assertions check the following:
- each strobe is a lone pulse that closes a status window of exactly UIP_LEAD counted ticks;
- the software hold, the chain hold, a zero rate and a cleared square-wave enable each silence their outputs one clock later;
- a square-wave rise only accompanies a periodic pulse;
- nothing fires without a reference tick.

Only the bench scenarios can show the absolute timing. This covers the half-second first update after release, the one-second spacing, and the exact delay added by a stop or an enable gap. It also covers the tap periods for each rate setting, including the clamp to one second, the skipped update when the software hold arrives inside the status window, and the prescaler phase being kept across that hold.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

   typedef enum logic [1:0] {
      CH_STOP = 2'd0,
      CH_RUN  = 2'd1,
      CH_HOLD = 2'd2
   } chain_mode_e;

   localparam int          CTRL_W   = 3;
   localparam logic [2:0]  RUN_CODE = 3'b010;

   // hold when both upper bits set, run on the one exact code, stop otherwise
   function automatic chain_mode_e decode_chain(input logic [CTRL_W-1:0] code);
      chain_mode_e m;
      if (code[2:1] == 2'b11)      m = CH_HOLD;
      else if (code == RUN_CODE)   m = CH_RUN;
      else                         m = CH_STOP;
      return m;
   endfunction

endpackage

// File: rtl/rtc_dv_decode.sv
module rtc_dv_decode
   import rtc_div_pkg::*;
(
   input  logic [CTRL_W-1:0] dv_sel,
   output chain_mode_e       mode
);

   assign mode = decode_chain(dv_sel);

endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
   import rtc_div_pkg::*;
#(
   parameter int DIV_W    = 15,
   parameter int UIP_LEAD = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_en,
   input  chain_mode_e      mode,
   input  logic             set_hold,
   output logic [DIV_W-1:0] cnt_o,
   output logic             adv_o,
   output logic             strobe_o,
   output logic             uip_o
);

   localparam logic [DIV_W-1:0] CNT_MAX  = {DIV_W{1'b1}};
   localparam logic [DIV_W-1:0] CNT_HALF = {1'b1, {(DIV_W-1){1'b0}}};
   localparam logic [DIV_W-1:0] LEAD_V   = DIV_W'(UIP_LEAD);
   localparam logic [DIV_W-1:0] ARM_AT   = CNT_MAX - LEAD_V;

   logic [DIV_W-1:0] cnt_q, cnt_d;
   logic             uip_q, uip_d;
   logic             strobe_q;
   logic             adv, at_max, fire;

   always_comb begin
      adv    = ref_en && (mode == CH_RUN);
      at_max = (cnt_q == CNT_MAX);
      // the update only happens if the full warning window was armed
      fire   = adv && at_max && uip_q && !set_hold;

      case (mode)
         CH_HOLD: cnt_d = CNT_HALF;
         CH_RUN:  cnt_d = adv ? cnt_q + 1'b1 : cnt_q;
         default: cnt_d = cnt_q;
      endcase

      if (mode == CH_HOLD || set_hold)  uip_d = 1'b0;
      else if (adv && at_max)           uip_d = 1'b0;
      else if (adv && cnt_q == ARM_AT)  uip_d = 1'b1;
      else                              uip_d = uip_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= CNT_HALF;
         uip_q    <= 1'b0;
         strobe_q <= 1'b0;
      end else begin
         cnt_q    <= cnt_d;
         uip_q    <= uip_d;
         strobe_q <= fire;
      end
   end

   assign cnt_o    = cnt_q;
   assign adv_o    = adv;
   assign strobe_o = strobe_q;
   assign uip_o    = uip_q;

endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap #(
   parameter int DIV_W  = 15,
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              hold,
   input  logic [DIV_W-1:0]  cnt,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              sqw_en,
   output logic              tick_o,
   output logic              sqw_o
);

   localparam int NTAP = 1 << RATE_W;

   logic [NTAP-1:0] hit;
   logic            tick_d, sqw_d, tick_q, sqw_q;

   assign hit[0] = 1'b0;

   for (genvar r = 1; r < NTAP; r++) begin : g_tap
      localparam int EXP = ((r - 1) > DIV_W) ? DIV_W : (r - 1);
      if (EXP == 0) begin : g_every
         assign hit[r] = 1'b1;
      end else begin : g_mask
         // the tap fires when the low EXP bits are about to wrap
         assign hit[r] = &cnt[EXP-1:0];
      end
   end

   always_comb begin
      tick_d = adv && hit[rate_sel];
      if (!sqw_en || rate_sel == '0 || hold) sqw_d = 1'b0;
      else if (tick_d)                       sqw_d = ~sqw_q;
      else                                   sqw_d = sqw_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= 1'b0;
         sqw_q  <= 1'b0;
      end else begin
         tick_q <= tick_d;
         sqw_q  <= sqw_d;
      end
   end

   assign tick_o = tick_q;
   assign sqw_o  = sqw_q;

endmodule

// File: rtl/rtc_divider_ctl.sv
module rtc_divider_ctl
   import rtc_div_pkg::*;
#(
   parameter int DIV_W    = 15,
   parameter int UIP_LEAD = 8,
   parameter int RATE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_en,
   input  logic [2:0]        dv_sel,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              sqw_en,
   input  logic              set_hold,
   output logic              upd_strobe,
   output logic              uip,
   output logic              per_tick,
   output logic              sqw_out
);

   localparam int HALF_TICKS = 1 << (DIV_W - 1);

   if (DIV_W < 2 || DIV_W > 24) begin : g_bad_div
      $error("DIV_W out of range");
   end
   if (UIP_LEAD < 1 || UIP_LEAD >= HALF_TICKS) begin : g_bad_lead
      $error("UIP_LEAD must lie between 1 and half the prescaler span");
   end
   if (RATE_W < 1 || RATE_W > 5) begin : g_bad_rate
      $error("RATE_W out of range");
   end

   chain_mode_e      mode;
   logic [DIV_W-1:0] cnt;
   logic             adv;

   rtc_dv_decode i_decode (
      .dv_sel (dv_sel),
      .mode   (mode)
   );

   rtc_update_seq #(
      .DIV_W    (DIV_W),
      .UIP_LEAD (UIP_LEAD)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_en   (ref_en),
      .mode     (mode),
      .set_hold (set_hold),
      .cnt_o    (cnt),
      .adv_o    (adv),
      .strobe_o (upd_strobe),
      .uip_o    (uip)
   );

   rtc_rate_tap #(
      .DIV_W  (DIV_W),
      .RATE_W (RATE_W)
   ) i_tap (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .hold     (mode == CH_HOLD),
      .cnt      (cnt),
      .rate_sel (rate_sel),
      .sqw_en   (sqw_en),
      .tick_o   (per_tick),
      .sqw_o    (sqw_out)
   );

endmodule

// File: rtl/rtc_divider_chk.sv
module rtc_divider_chk #(
   parameter int DIV_W    = 15,
   parameter int UIP_LEAD = 8,
   parameter int RATE_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_en,
   input logic [2:0]        dv_sel,
   input logic [RATE_W-1:0] rate_sel,
   input logic              sqw_en,
   input logic              set_hold,
   input logic              upd_strobe,
   input logic              uip,
   input logic              per_tick,
   input logic              sqw_out
);

   localparam int SW = $clog2(UIP_LEAD + 1) + 1;
   localparam logic [SW-1:0] SEEN_TOP  = {SW{1'b1}};
   localparam logic [SW-1:0] SEEN_GOAL = SW'(UIP_LEAD - 1);

   logic [SW-1:0] lead_seen;
   logic          run_now, stop_now;

   assign run_now  = (dv_sel == 3'b010);
   assign stop_now = !run_now && (dv_sel[2:1] != 2'b11);

   // counts reference ticks that pass while the status bit is already up
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          lead_seen <= '0;
      else if (!uip)                                       lead_seen <= '0;
      else if (ref_en && run_now && lead_seen != SEEN_TOP) lead_seen <= lead_seen + 1'b1;
   end

   // R6
   strobe_closes_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_strobe |-> ($past(uip) && !uip));

   // R6
   uip_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_strobe |-> ($past(lead_seen) == SEEN_GOAL));

   // R5
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_strobe |=> !upd_strobe);

   // R7
   set_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_hold |=> (!upd_strobe && !uip));

   // R2
   hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dv_sel[2:1] == 2'b11) |=> (!upd_strobe && !uip && !per_tick && !sqw_out));

   // R3
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_now |=> (!upd_strobe && !per_tick && $stable(sqw_out)));

   // R8
   rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == '0) |=> (!per_tick && !sqw_out));

   // R10
   sqw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sqw_en |=> !sqw_out);

   // R10
   sqw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sqw_out) |-> per_tick);

   // R11
   idle_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_en |=> (!upd_strobe && !per_tick));

   // R1
   always_comb begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!upd_strobe && !uip && !per_tick && !sqw_out);
      end
   end

endmodule

bind rtc_divider_ctl rtc_divider_chk #(
   .DIV_W    (DIV_W),
   .UIP_LEAD (UIP_LEAD),
   .RATE_W   (RATE_W)
) i_chk (.*);

// File: tb/test_rtc_divider_ctl.sv
module test_rtc_divider_ctl;

   localparam int DW   = 8;
   localparam int LEAD = 4;
   localparam int RW   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_en = 1'b1;
   logic [2:0]    dv_sel = 3'b110;
   logic [RW-1:0] rate_sel = '0;
   logic          sqw_en = 1'b0;
   logic          set_hold = 1'b0;
   logic          upd_strobe, uip, per_tick, sqw_out;

   rtc_divider_ctl #(.DIV_W(DW), .UIP_LEAD(LEAD), .RATE_W(RW)) i_rtc_divider_ctl (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .dv_sel(dv_sel),
      .rate_sel(rate_sel), .sqw_en(sqw_en), .set_hold(set_hold),
      .upd_strobe(upd_strobe), .uip(uip), .per_tick(per_tick), .sqw_out(sqw_out)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int strobe_exp[$];
   int uip_exp[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   bit uip_prev = 1'b0;
   int w_uip, w_tick, w_strobe, w_hi, w_tog, w_mis;
   int c0, c1;

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // monitor: pops the expected cycle of each strobe and each status rise
   always @(negedge clk) begin
      int e;
      if (rst_n) begin
         if (upd_strobe) begin
            check(!uip, "R6 uip must be low with strobe", int'(uip), 0);
            if (strobe_exp.size() == 0) check(1'b0, "R5 unexpected strobe", cyc, -1);
            else begin
               e = strobe_exp.pop_front();
               check(cyc == e, "R4 strobe cycle", cyc, e);
            end
         end
         if (uip && !uip_prev) begin
            if (uip_exp.size() == 0) check(1'b0, "R6 unexpected uip rise", cyc, -1);
            else begin
               e = uip_exp.pop_front();
               check(cyc == e, "R6 uip rise cycle", cyc, e);
            end
         end
         uip_prev = uip;
      end
   end

   // steps negedge by negedge up to cycle t, tallying outputs
   task automatic watch(input int t);
      logic prev;
      w_uip = 0; w_tick = 0; w_strobe = 0; w_hi = 0; w_tog = 0; w_mis = 0;
      prev = sqw_out;
      while (cyc != t) begin
         @(negedge clk);
         w_uip    += int'(uip);
         w_tick   += int'(per_tick);
         w_strobe += int'(upd_strobe);
         w_hi     += int'(sqw_out);
         if (sqw_out != prev) w_tog++;
         if (per_tick != upd_strobe) w_mis++;
         prev = sqw_out;
      end
   endtask

   task automatic rate_window(input logic [RW-1:0] r, input logic en, input int len);
      rate_sel = r;
      sqw_en   = en;
      @(negedge clk);
      watch(cyc + len);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!upd_strobe, "R1 reset strobe", int'(upd_strobe), 0);
      check(!uip,        "R1 reset uip",    int'(uip), 0);
      check(!per_tick,   "R1 reset tick",   int'(per_tick), 0);
      check(!sqw_out,    "R1 reset sqw",    int'(sqw_out), 0);
      rst_n = 1'b1;
      watch(6);

      // release from hold: half second to first update, then one per second
      c0 = cyc;
      dv_sel = 3'b010;
      for (int m = 0; m < 4; m++) begin
         uip_exp.push_back(c0 + 124 + 256 * m);
         strobe_exp.push_back(c0 + 128 + 256 * m);
      end
      watch(c0 + 10);

      rate_window(4'd3, 1'b1, 64);
      check(w_tick == 16, "R9 rate 3 tick count", w_tick, 16);
      check(w_tog == 16,  "R10 rate 3 sqw toggles", w_tog, 16);
      rate_window(4'd1, 1'b1, 64);
      check(w_tick == 64, "R9 rate 1 tick count", w_tick, 64);
      check(w_tog == 64,  "R10 rate 1 sqw toggles", w_tog, 64);
      rate_window(4'd0, 1'b1, 64);
      check(w_tick == 0,  "R8 rate 0 tick count", w_tick, 0);
      check(w_hi == 0,    "R8 rate 0 sqw high samples", w_hi, 0);
      rate_window(4'd3, 1'b0, 64);
      check(w_tick == 16, "R10 ticks with sqw disabled", w_tick, 16);
      check(w_hi == 0,    "R10 sqw low when disabled", w_hi, 0);
      rate_window(4'd12, 1'b0, 512);
      check(w_tick == 2,  "R9 clamped tap count", w_tick, 2);
      check(w_mis == 0,   "R9 clamped tap aligned with strobe", w_mis, 0);
      rate_sel = 4'd1;
      sqw_en   = 1'b1;

      // software hold: no updates, status low, prescaler keeps phase
      watch(c0 + 900);
      set_hold = 1'b1;
      watch(c0 + 1200);
      check(w_uip == 0,    "R7 uip low under set", w_uip, 0);
      check(w_strobe == 0, "R7 no strobe under set", w_strobe, 0);
      check(w_tick == 300, "R7 periodic tick keeps running", w_tick, 300);
      set_hold = 1'b0;
      uip_exp.push_back(c0 + 1404);
      strobe_exp.push_back(c0 + 1408);
      uip_exp.push_back(c0 + 1660);
      uip_exp.push_back(c0 + 1916);
      strobe_exp.push_back(c0 + 1920);
      watch(c0 + 1660);
      check(uip == 1'b1, "R6 uip up inside window", int'(uip), 1);
      set_hold = 1'b1;
      @(negedge clk);
      check(uip == 1'b0, "R7 set clears uip", int'(uip), 0);
      watch(c0 + 1670);
      check(w_strobe == 0, "R7 armed update skipped", w_strobe, 0);
      set_hold = 1'b0;

      // chain hold, then a stop of 100 cycles after release
      watch(c0 + 1930);
      dv_sel = 3'b111;
      watch(c0 + 1980);
      check(w_uip == 0,    "R2 hold uip", w_uip, 0);
      check(w_tick == 0,   "R2 hold tick", w_tick, 0);
      check(w_strobe == 0, "R2 hold strobe", w_strobe, 0);
      check(w_hi == 0,     "R2 hold sqw", w_hi, 0);
      c1 = cyc;
      dv_sel = 3'b010;
      uip_exp.push_back(c1 + 224);
      strobe_exp.push_back(c1 + 228);
      watch(c1 + 50);
      dv_sel = 3'b000;
      watch(c1 + 150);
      check(w_tick == 0,   "R3 stop tick", w_tick, 0);
      check(w_strobe == 0, "R3 stop strobe", w_strobe, 0);
      check(w_tog == 0,    "R3 stop sqw frozen", w_tog, 0);
      dv_sel = 3'b010;

      // reference enable gap of 100 cycles
      watch(c1 + 230);
      ref_en = 1'b0;
      uip_exp.push_back(c1 + 580);
      strobe_exp.push_back(c1 + 584);
      watch(c1 + 330);
      check(w_tick == 0,   "R11 no tick without ref", w_tick, 0);
      check(w_strobe == 0, "R11 no strobe without ref", w_strobe, 0);
      ref_en = 1'b1;
      watch(c1 + 600);

      check(strobe_exp.size() == 0, "R4 missing strobes", strobe_exp.size(), 0);
      check(uip_exp.size() == 0,    "R6 missing uip rises", uip_exp.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         summary();
         $finish;
      end
   end

endmodule